// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block decides which receive mailbox takes an incoming CAN frame. It holds a bank of mailboxes. Each has an identifier in two 16-bit words, three control flags in the upper word, and its own acceptance mask. When a frame descriptor arrives, every active mailbox compares it with its own identifier. The lowest-numbered mailbox that matches wins: its receive-pending bit is set and its index is reported with a one-cycle hit strobe.

Software fills the mailbox fields through a simple write port. It releases pending bits through a write-one-to-clear vector. If a new frame lands in a mailbox whose pending bit is still set, the block raises a sticky message-lost flag for that mailbox. Bit-level framing, payload storage and transmit arbitration are handled elsewhere.

Top module: `can_rx_filter`

## Requirements
- R1: After reset, `hit`, `pend` and `lost` are all zero. All mailbox identifiers, masks, enable bits and direction bits are zero.
- R2: When `wr_en` is 1, a write stores `wr_data` at the next clock into the field chosen by `wr_sel`. The selector codes are: 0 = low identifier word, 1 = high identifier word, 2 = low mask word, 3 = high mask word (bits 12:0 of `wr_data`), 4 = mailbox-enable vector, 5 = direction vector. For codes 0 to 3, `wr_mb` picks the mailbox.
- R3: A standard frame (`frm_ide`=0) is compared on `frm_id[10:0]` only, against bits 12:2 of the high identifier word. A frame is accepted only when `frm_ide` equals bit 13 of the high word.
- R4: An extended frame (`frm_ide`=1) is compared on `frm_id[28:16]` against bits 12:0 of the high word, and on `frm_id[15:0]` against the low word.
- R5: When bit 15 of the high word is 1, a mask bit of 1 makes the matching identifier bit don't-care. The high mask bits 12:0 line up with the high word bits 12:0, and the low mask lines up with the low word. When bit 15 is 0, every identifier bit must match exactly.
- R6: A frame is accepted only when `frm_rtr` equals bit 14 of the high identifier word.
- R7: A mailbox takes part in matching only when its enable bit is 1 and its direction bit is 1 (receive).
- R8: The clock edge that samples `frm_valid`=1 with at least one matching mailbox makes `hit` 1 for one cycle. The same edge loads the index of the lowest-numbered matching mailbox into `hit_idx` and sets only that mailbox's `pend` bit. `hit_idx` holds its value while `hit` is 0.
- R9: If the winning mailbox's pending bit is already set, and is not cleared in the same cycle, its `lost` bit is set. The pending bit stays set.
- R10: A 1 in `pend_clr` clears that mailbox's `pend` and `lost` bits at the next edge. If a clear and a new win on the same mailbox fall in the same cycle, the clear is applied first: `pend` ends at 1 and `lost` ends at 0.
- R11: A frame that matches no active mailbox leaves `hit` at 0, and `pend` and `lost` unchanged apart from any clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Field selector for the write |
| wr_mb | input | 4 | Mailbox index for per-mailbox fields |
| wr_data | input | 16 | Write data |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_ide | input | 1 | Frame uses the extended identifier |
| frm_rtr | input | 1 | Frame is a remote request |
| frm_id | input | 29 | Frame identifier (standard in bits 10:0) |
| pend_clr | input | 16 | Write-one-to-clear for pending and lost bits |
| hit | output | 1 | One-cycle strobe for an accepted frame |
| hit_idx | output | 4 | Index of the winning mailbox |
| pend | output | 16 | Receive-pending bits |
| lost | output | 16 | Sticky message-lost bits |

## Verification
Software can release a mailbox's pending bit in the same cycle that a new frame is accepted into that mailbox. The bench forces this by holding `pend_clr` on a pending mailbox while it presents a frame that mailbox wins. It also lets the random phase hit the same situation. The result is judged by `pend` staying 1 and `lost` staying 0, which the bench model predicts by applying the clear before the set.

// File: rtl/canf_pkg.sv
package canf_pkg;
  localparam int ID_W    = 29;
  localparam int WORD_W  = 16;
  localparam int MHI_W   = 13;
  localparam int AME_BIT = 15;
  localparam int RTR_BIT = 14;
  localparam int IDE_BIT = 13;

  typedef enum logic [2:0] {
    SEL_ID_LO  = 3'd0,
    SEL_ID_HI  = 3'd1,
    SEL_MSK_LO = 3'd2,
    SEL_MSK_HI = 3'd3,
    SEL_ENABLE = 3'd4,
    SEL_DIR    = 3'd5
  } wsel_e;

  typedef struct packed {
    logic            ide;
    logic            rtr;
    logic [ID_W-1:0] id;
  } frame_t;
endpackage

// File: rtl/canf_mb_match.sv
module canf_mb_match
  import canf_pkg::*;
(
  input  logic              active,
  input  logic [WORD_W-1:0] id_hi,
  input  logic [WORD_W-1:0] id_lo,
  input  logic [MHI_W-1:0]  msk_hi,
  input  logic [WORD_W-1:0] msk_lo,
  input  frame_t            frm,
  output logic              match
);
  logic [MHI_W-1:0]  f_hi, care_hi;
  logic [WORD_W-1:0] f_lo, care_lo;
  logic              flags_ok;

  always_comb begin
    if (frm.ide) begin
      f_hi    = frm.id[ID_W-1:WORD_W];
      f_lo    = frm.id[WORD_W-1:0];
      care_hi = '1;
      care_lo = '1;
    end else begin
      f_hi    = {frm.id[10:0], 2'b00};
      f_lo    = '0;
      care_hi = {{(MHI_W-2){1'b1}}, 2'b00};
      care_lo = '0;
    end
    if (id_hi[AME_BIT]) begin
      care_hi = care_hi & ~msk_hi;
      care_lo = care_lo & ~msk_lo;
    end
    flags_ok = (frm.ide == id_hi[IDE_BIT]) && (frm.rtr == id_hi[RTR_BIT]);
    match = active && flags_ok
         && (((f_hi ^ id_hi[MHI_W-1:0]) & care_hi) == '0)
         && (((f_lo ^ id_lo) & care_lo) == '0);
  end
endmodule

// File: rtl/canf_prio.sv
module canf_prio #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    gnt = '0;
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt    = '0;
        gnt[i] = 1'b1;
        idx    = IW'(i);
        any    = 1'b1;
      end
    end
  end

  // R8
  always_comb begin
    gnt_onehot_chk: assert ($onehot0(gnt) && ((gnt & ~req) == '0) && (any == (req != '0)));
  end
endmodule

// File: rtl/can_rx_filter.sv
module can_rx_filter
  import canf_pkg::*;
#(
  parameter int NUM_MB = 16,
  localparam int MBW   = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [MBW-1:0]    wr_mb,
  input  logic [15:0]       wr_data,
  input  logic              frm_valid,
  input  logic              frm_ide,
  input  logic              frm_rtr,
  input  logic [28:0]       frm_id,
  input  logic [NUM_MB-1:0] pend_clr,
  output logic              hit,
  output logic [MBW-1:0]    hit_idx,
  output logic [NUM_MB-1:0] pend,
  output logic [NUM_MB-1:0] lost
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  // mailbox field registers
  logic [WORD_W-1:0] id_lo_q [NUM_MB], id_lo_d [NUM_MB];
  logic [WORD_W-1:0] id_hi_q [NUM_MB], id_hi_d [NUM_MB];
  logic [WORD_W-1:0] mk_lo_q [NUM_MB], mk_lo_d [NUM_MB];
  logic [MHI_W-1:0]  mk_hi_q [NUM_MB], mk_hi_d [NUM_MB];
  logic [NUM_MB-1:0] en_q, en_d, dir_q, dir_d;

  always_comb begin
    id_lo_d = id_lo_q;
    id_hi_d = id_hi_q;
    mk_lo_d = mk_lo_q;
    mk_hi_d = mk_hi_q;
    en_d    = en_q;
    dir_d   = dir_q;
    if (wr_en) begin
      case (wsel_e'(wr_sel))
        SEL_ID_LO:  id_lo_d[wr_mb] = wr_data;
        SEL_ID_HI:  id_hi_d[wr_mb] = wr_data;
        SEL_MSK_LO: mk_lo_d[wr_mb] = wr_data;
        SEL_MSK_HI: mk_hi_d[wr_mb] = wr_data[MHI_W-1:0];
        SEL_ENABLE: en_d           = wr_data[NUM_MB-1:0];
        SEL_DIR:    dir_d          = wr_data[NUM_MB-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      for (int i = 0; i < NUM_MB; i++) begin
        id_lo_q[i] <= '0;
        id_hi_q[i] <= '0;
        mk_lo_q[i] <= '0;
        mk_hi_q[i] <= '0;
      end
      en_q  <= '0;
      dir_q <= '0;
    end else if (wr_en) begin
      id_lo_q <= id_lo_d;
      id_hi_q <= id_hi_d;
      mk_lo_q <= mk_lo_d;
      mk_hi_q <= mk_hi_d;
      en_q    <= en_d;
      dir_q   <= dir_d;
    end
  end

  // per-mailbox comparators
  frame_t            frm;
  logic [NUM_MB-1:0] req, gnt;
  logic [MBW-1:0]    win_idx;
  logic              win_any;

  assign frm = '{ide: frm_ide, rtr: frm_rtr, id: frm_id};

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    canf_mb_match u_match (
      .active (en_q[g] & dir_q[g]),
      .id_hi  (id_hi_q[g]),
      .id_lo  (id_lo_q[g]),
      .msk_hi (mk_hi_q[g]),
      .msk_lo (mk_lo_q[g]),
      .frm    (frm),
      .match  (req[g])
    );
  end

  canf_prio #(.N(NUM_MB)) u_prio (
    .req (req),
    .gnt (gnt),
    .idx (win_idx),
    .any (win_any)
  );

  // pending / lost state
  logic              fire, hit_d;
  logic [MBW-1:0]    idx_d;
  logic [NUM_MB-1:0] win, kept, pend_d, lost_d;

  always_comb begin
    fire   = frm_valid & win_any;
    win    = fire ? gnt : '0;
    kept   = pend & ~pend_clr;
    pend_d = kept | win;
    lost_d = (lost & ~pend_clr) | (win & kept);
    hit_d  = fire;
    idx_d  = fire ? win_idx : hit_idx;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      hit     <= 1'b0;
      hit_idx <= '0;
      pend    <= '0;
      lost    <= '0;
    end else begin
      hit     <= hit_d;
      hit_idx <= idx_d;
      pend    <= pend_d;
      lost    <= lost_d;
    end
  end

  // R8
  hit_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_q)
    hit |-> pend[hit_idx]);

  // R8
  single_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $countones(pend & ~$past(pend)) <= 1);

  // R11
  hit_needs_frame_chk: assert property (@(posedge clk) disable iff (!rst_q)
    hit |-> $past(frm_valid));

  // R7
  idle_bank_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (frm_valid && ((en_q & dir_q) == '0)) |=> !hit);

  // R9
  lost_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_q)
    ((lost & ~$past(lost)) != '0) |-> hit);
endmodule

// File: tb/can_rx_filter_test.sv
module can_rx_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int NMB = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [3:0]  wr_mb;
  logic [15:0] wr_data;
  logic        frm_valid, frm_ide, frm_rtr;
  logic [28:0] frm_id;
  logic [15:0] pend_clr;
  logic        hit;
  logic [3:0]  hit_idx;
  logic [15:0] pend, lost;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_rx_filter uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_mb(wr_mb),
    .wr_data(wr_data), .frm_valid(frm_valid), .frm_ide(frm_ide), .frm_rtr(frm_rtr),
    .frm_id(frm_id), .pend_clr(pend_clr), .hit(hit), .hit_idx(hit_idx),
    .pend(pend), .lost(lost)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  logic [15:0] m_idlo [NMB];
  logic [15:0] m_idhi [NMB];
  logic [15:0] m_mlo  [NMB];
  logic [12:0] m_mhi  [NMB];
  logic [15:0] m_en, m_dir, m_pend, m_lost;
  logic [3:0]  m_idx;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic mdl_match(int i, logic ide, logic rtr, logic [28:0] id);
    logic        ame;
    logic [28:0] want, dc;
    logic [10:0] want_s, dc_s;
    ame = m_idhi[i][15];
    if (!(m_en[i] && m_dir[i])) return 1'b0;
    if (m_idhi[i][13] != ide || m_idhi[i][14] != rtr) return 1'b0;
    if (ide) begin
      want = {m_idhi[i][12:0], m_idlo[i]};
      dc   = ame ? {m_mhi[i], m_mlo[i]} : 29'd0;
      return ((want ^ id) & ~dc) == 29'd0;
    end
    want_s = m_idhi[i][12:2];
    dc_s   = ame ? m_mhi[i][12:2] : 11'd0;
    return ((want_s ^ id[10:0]) & ~dc_s) == 11'd0;
  endfunction

  task automatic wr(logic [2:0] sel, logic [3:0] mb, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_mb = mb; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (sel)
      3'd0: m_idlo[mb] = d;
      3'd1: m_idhi[mb] = d;
      3'd2: m_mlo[mb]  = d;
      3'd3: m_mhi[mb]  = d[12:0];
      3'd4: m_en       = d;
      3'd5: m_dir      = d;
      default: ;
    endcase
  endtask

  task automatic set_mb(int k, logic ide, logic rtr, logic ame, logic [28:0] id,
                        logic [12:0] mhi, logic [15:0] mlo);
    logic [15:0] hi;
    hi = {ame, rtr, ide, 13'd0};
    if (ide) hi[12:0] = id[28:16];
    else     hi[12:2] = id[10:0];
    wr(3'd1, 4'(k), hi);
    wr(3'd0, 4'(k), ide ? id[15:0] : 16'd0);
    wr(3'd3, 4'(k), {3'd0, mhi});
    wr(3'd2, 4'(k), mlo);
  endtask

  // present one frame, compare with the model one edge later
  task automatic frame(logic ide, logic rtr, logic [28:0] id, logic [15:0] clr, string tag);
    logic        e_hit;
    int          w;
    logic [15:0] kept;
    e_hit = 1'b0; w = 0;
    for (int i = NMB - 1; i >= 0; i--) if (mdl_match(i, ide, rtr, id)) begin e_hit = 1'b1; w = i; end
    @(negedge clk);
    frm_valid = 1'b1; frm_ide = ide; frm_rtr = rtr; frm_id = id; pend_clr = clr;
    @(negedge clk);
    frm_valid = 1'b0; pend_clr = '0;
    kept = m_pend & ~clr;
    m_lost = m_lost & ~clr;
    if (e_hit) begin
      if (kept[w]) m_lost[w] = 1'b1;
      kept[w] = 1'b1;
      m_idx = 4'(w);
    end
    m_pend = kept;
    chk({tag, " hit"}, 32'(hit), 32'(e_hit));
    chk({tag, " idx"}, 32'(hit_idx), 32'(m_idx));
    chk({tag, " pend"}, 32'(pend), 32'(m_pend));
    chk({tag, " lost"}, 32'(lost), 32'(m_lost));
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R8 watchdog act=running exp=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'd7321));
    for (int i = 0; i < NMB; i++) begin
      m_idlo[i] = '0; m_idhi[i] = '0; m_mlo[i] = '0; m_mhi[i] = '0;
    end
    m_en = '0; m_dir = '0; m_pend = '0; m_lost = '0; m_idx = '0;
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_mb = '0; wr_data = '0;
    frm_valid = 1'b0; frm_ide = 1'b0; frm_rtr = 1'b0; frm_id = '0; pend_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 hit", 32'(hit), 32'd0);
    chk("R1 pend", 32'(pend), 32'd0);
    chk("R1 lost", 32'(lost), 32'd0);
    frame(1'b0, 1'b0, 29'd0, '0, "R1 empty bank");

    // R2 R3 exact standard id in mailbox 0
    set_mb(0, 1'b0, 1'b0, 1'b0, 29'h123, 13'h0, 16'h0);
    wr(3'd4, 4'd0, 16'h000F);
    wr(3'd5, 4'd0, 16'h0007);
    frame(1'b0, 1'b0, 29'h1FFFF123, '0, "R3 std match upper bits ignored");
    chk("R8 idx explicit", 32'(hit_idx), 32'd0);
    chk("R8 pend explicit", 32'(pend), 32'h1);
    frame(1'b0, 1'b0, 29'h124, '0, "R11 std miss");
    frame(1'b1, 1'b0, 29'h123, '0, "R3 ide mismatch");
    frame(1'b0, 1'b1, 29'h123, '0, "R6 rtr mismatch");
    frame(1'b0, 1'b0, 29'h123, '0, "R9 lost");
    chk("R9 lost explicit", 32'(lost), 32'h1);
    frame(1'b0, 1'b0, 29'h555, 16'h0001, "R10 clear");
    chk("R10 pend explicit", 32'(pend), 32'h0);

    // R4 R5 extended with mask
    set_mb(1, 1'b1, 1'b0, 1'b1, 29'h1ABCDEF, 13'h0, 16'h000F);
    frame(1'b1, 1'b0, 29'h1ABCDE5, '0, "R5 masked ext match");
    chk("R4 idx explicit", 32'(hit_idx), 32'd1);
    frame(1'b1, 1'b0, 29'h0ABCDEF, '0, "R4 ext high miss");
    set_mb(2, 1'b1, 1'b0, 1'b0, 29'h55, 13'h1FFF, 16'hFFFF);
    frame(1'b1, 1'b0, 29'h56, '0, "R5 mask off exact");
    frame(1'b1, 1'b0, 29'h55, '0, "R4 ext exact");

    // R7 accept-all mailbox 3, transmit direction first
    set_mb(3, 1'b0, 1'b0, 1'b1, 29'h0, 13'h1FFF, 16'h0);
    frame(1'b0, 1'b0, 29'h7FF, 16'hFFFF, "R7 tx direction");
    wr(3'd5, 4'd0, 16'h000F);
    frame(1'b0, 1'b0, 29'h7FF, '0, "R7 rx direction");
    chk("R7 idx explicit", 32'(hit_idx), 32'd3);
    frame(1'b0, 1'b0, 29'h123, '0, "R8 lowest wins");
    chk("R8 single pend", 32'(pend), 32'h9);
    wr(3'd4, 4'd0, 16'h0007);
    frame(1'b0, 1'b0, 29'h7FF, '0, "R7 disabled");

    // R10 clear and win on same mailbox in one cycle
    frame(1'b0, 1'b0, 29'h123, 16'h0001, "R10 clear with win");
    chk("R10 pend bit0", 32'(pend[0]), 32'd1);
    chk("R10 lost bit0", 32'(lost[0]), 32'd0);

    // random phase
    for (int n = 0; n < 300; n++) begin
      logic        ide, rtr;
      logic [28:0] id;
      logic [15:0] clr;
      if (n % 15 == 0) begin
        int k;
        logic [28:0] base;
        k = $urandom_range(0, NMB - 1);
        ide = $urandom_range(0, 1);
        base = ide ? {25'h1ABCDE, 4'h0} : 29'h120;
        set_mb(k, ide, ($urandom_range(0, 5) == 0), $urandom_range(0, 1),
               base | 29'($urandom_range(0, 7)),
               13'($urandom_range(0, 1) ? 13'h000C : 13'h0),
               16'($urandom_range(0, 1) ? 16'h0003 : 16'h0));
        wr(3'd4, 4'd0, 16'($urandom) | 16'hF000);
        wr(3'd5, 4'd0, 16'($urandom) | 16'hF000);
      end
      ide = $urandom_range(0, 1);
      rtr = ($urandom_range(0, 7) == 0);
      id  = ide ? {25'h1ABCDE, 4'($urandom_range(0, 15))} : (29'h120 | 29'($urandom_range(0, 15)));
      clr = ($urandom_range(0, 3) == 0) ? 16'($urandom) : 16'h0;
      frame(ide, rtr, id, clr, "R8 random");
    end

    done = 1'b1;
    summary();
  end
endmodule